// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a flash device and works out when an embedded program or erase operation has finished and whether it succeeded. Once started with an address, an operation kind (program or erase), a checking method and a poll limit, it reads the target location again and again through a single read port. After each read it decides from the returned status bits whether to read again, to make the one extra check that a raised error bit calls for, or to finish. A finished program operation is followed by one verify read of the whole byte.

Two checking methods are available. Data polling compares bit 7 of the status byte with the bit the finished operation should leave there. Toggle checking looks for bit 6 to hold steady across two back-to-back reads. In both methods bit 5 is the error bit, and when it is seen the block makes one recheck before it gives a fail. A poll limit ends a run that never settles with a fail and a timeout flag.

The read request side is valid/ready. `rd_req_valid` rises together with `rd_addr` and both stay unchanged until the cycle in which `rd_req_ready` is high, so the device side can hold off a read for any number of cycles. The response side has no ready. Only one read is ever outstanding and the block always waits for it, so a one-cycle `rd_rsp_valid` pulse is always taken. Start, mode and result pins are plain level or pulse signals.

Top module: `flash_status_poller`

## Requirements
- R1: After reset `busy`, `rd_req_valid`, `done`, `pass`, `fail` and `timeout` are low and `read_count` is 0.
- R2: A `start` pulse while idle latches the inputs and raises `rd_req_valid` with `rd_addr` equal to the latched address. The request holds unchanged until `rd_req_ready` is high. A `start` while busy is ignored and leaves the running operation and its address unchanged.
- R3: In data-polling mode (`mode_toggle`=0), a status byte whose bit 7 equals the expected bit ends polling. The expected bit is `exp_data[7]` for a program (`op_program`=1) and 1 for an erase.
- R4: In data-polling mode, a status byte with bit 7 not matching and bit 5 = 0 causes another read.
- R5: In data-polling mode, a status byte with bit 7 not matching and bit 5 = 1 causes exactly one more read. If bit 7 matches on that read, polling ends; if it does not, the result is fail.
- R6: In toggle mode (`mode_toggle`=1), polling ends when bit 6 of a read equals bit 6 of the read just before it. Bit 5 is not consulted in that case.
- R7: In toggle mode, a read whose bit 6 differs from the previous read while bit 5 = 1 starts a new pair of reads. If bit 6 is equal across that pair, polling ends; if it differs, the result is fail.
- R8: When polling ends for a program, one verify read follows. The result is pass only if all 8 bits equal `exp_data`. When polling ends for an erase, the result is pass with no further read.
- R9: Status reads, counting rechecks, are limited to `poll_limit`. A result that would need another status read after `poll_limit` of them gives fail together with `timeout`. A result reached on the last allowed read stands, and the verify read is not counted against the limit.
- R10: The result is a one-cycle `done` pulse in the cycle after the final response. Exactly one of `pass`/`fail` is high with it, and `timeout` is high only together with `fail`.
- R11: `read_count` equals the number of responses taken in the current operation. It is cleared by an accepted `start` and holds its value after `done`.
- R12: At most one read is outstanding. No new request is raised before the response to the previous one, and no request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation check (taken only while idle) |
| op_program | input | 1 | 1 = program operation, 0 = erase |
| mode_toggle | input | 1 | 1 = toggle checking, 0 = data polling |
| addr | input | AW | Location to poll |
| exp_data | input | 8 | Intended byte for a program |
| poll_limit | input | CW | Maximum number of status reads |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by the device side |
| rd_addr | output | AW | Read request address |
| rd_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| rd_rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result pulse |
| pass | output | 1 | Operation succeeded (with done) |
| fail | output | 1 | Operation failed (with done) |
| timeout | output | 1 | Failure caused by the poll limit (with done) |
| read_count | output | CW | Responses taken in the current operation |

## Verification
The assertions check on every cycle the rules that hold whatever data comes back. These are the request hold under back-pressure, no request while idle, the single-cycle `done` carrying exactly one verdict with `timeout` only beside `fail`, and `read_count` changing only on a response or an accepted start. Whether a given sequence of status bytes ends in pass, fail or timeout, and after how many reads, depends on the bit-5, bit-6 and bit-7 decision rules and on the limit count. Only the bench's scripted device responses can show that, comparing each verdict and count against values worked out from the rules above.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int BYTE_W   = 8;
  localparam int BIT_DONE = 7;  // data-polling flag
  localparam int BIT_TGL  = 6;  // toggling flag
  localparam int BIT_ERR  = 5;  // error flag

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    PH_POLL,
    PH_RECHECK,
    PH_VERIFY
  } phase_e;

  typedef enum logic [2:0] {
    DEC_AGAIN,
    DEC_RECHECK,
    DEC_VERIFY,
    DEC_PASS,
    DEC_FAIL
  } dec_e;

endpackage

// File: rtl/poll_eval.sv
module poll_eval
  import flash_poll_pkg::*;
(
  input  logic              mode_toggle,
  input  logic              op_program,
  input  phase_e            phase,
  input  logic              have_prev,
  input  logic              prev_tgl,
  input  logic [BYTE_W-1:0] exp_byte,
  input  logic [BYTE_W-1:0] rsp,
  output dec_e              dec
);

  logic exp_flag;
  logic flag_ok;
  logic tgl_same;
  dec_e settled;

  assign exp_flag = op_program ? exp_byte[BIT_DONE] : 1'b1;
  assign flag_ok  = (rsp[BIT_DONE] == exp_flag);
  assign tgl_same = (rsp[BIT_TGL] == prev_tgl);
  assign settled  = op_program ? DEC_VERIFY : DEC_PASS;

  always_comb begin
    dec = DEC_FAIL;
    unique case (phase)
      PH_VERIFY: dec = (rsp == exp_byte) ? DEC_PASS : DEC_FAIL;
      PH_POLL: begin
        if (!mode_toggle) begin
          if (flag_ok)            dec = settled;
          else if (rsp[BIT_ERR])  dec = DEC_RECHECK;
          else                    dec = DEC_AGAIN;
        end else begin
          if (!have_prev)         dec = DEC_AGAIN;
          else if (tgl_same)      dec = settled;
          else if (rsp[BIT_ERR])  dec = DEC_RECHECK;
          else                    dec = DEC_AGAIN;
        end
      end
      PH_RECHECK: begin
        if (!mode_toggle)         dec = flag_ok ? settled : DEC_FAIL;
        else if (!have_prev)      dec = DEC_AGAIN;
        else                      dec = tgl_same ? settled : DEC_FAIL;
      end
      default: dec = DEC_FAIL;
    endcase
  end

endmodule

// File: rtl/poll_count.sv
module poll_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          room
);

  localparam int EW = CW + 1;

  logic [EW-1:0] next_ext;

  assign next_ext = {1'b0, count} + EW'(1);
  // room: the read now completing still leaves space for one more status read
  assign room     = next_ext < {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= next_ext[CW-1:0];
  end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import flash_poll_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_program,
  input  logic              mode_toggle,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] exp_data,
  input  logic [CW-1:0]     poll_limit,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [BYTE_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout,
  output logic [CW-1:0]     read_count
);

  st_e               state_q;
  phase_e            phase_q;
  logic              prog_q;
  logic              tgl_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] exp_q;
  logic [CW-1:0]     limit_q;
  logic              have_prev_q;
  logic              prev_tgl_q;

  logic start_take;
  logic rsp_take;
  logic room;
  dec_e dec;

  assign start_take = (state_q == ST_IDLE) && start;
  assign rsp_take   = (state_q == ST_WAIT) && rd_rsp_valid;

  poll_eval u_eval (
    .mode_toggle (tgl_q),
    .op_program  (prog_q),
    .phase       (phase_q),
    .have_prev   (have_prev_q),
    .prev_tgl    (prev_tgl_q),
    .exp_byte    (exp_q),
    .rsp         (rd_rsp_data),
    .dec         (dec)
  );

  poll_count #(.CW(CW)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_take),
    .inc   (rsp_take),
    .limit (limit_q),
    .count (read_count),
    .room  (room)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_POLL;
      prog_q      <= 1'b0;
      tgl_q       <= 1'b0;
      addr_q      <= '0;
      exp_q       <= '0;
      limit_q     <= '0;
      have_prev_q <= 1'b0;
      prev_tgl_q  <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            prog_q      <= op_program;
            tgl_q       <= mode_toggle;
            addr_q      <= addr;
            exp_q       <= exp_data;
            limit_q     <= poll_limit;
            phase_q     <= PH_POLL;
            have_prev_q <= 1'b0;
            state_q     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            unique case (dec)
              DEC_AGAIN, DEC_RECHECK: begin
                if (!room) begin
                  done    <= 1'b1;
                  fail    <= 1'b1;
                  timeout <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  if (dec == DEC_AGAIN) begin
                    have_prev_q <= 1'b1;
                    prev_tgl_q  <= rd_rsp_data[BIT_TGL];
                  end else begin
                    phase_q     <= PH_RECHECK;
                    have_prev_q <= 1'b0;
                  end
                  state_q <= ST_REQ;
                end
              end
              DEC_VERIFY: begin
                phase_q <= PH_VERIFY;
                state_q <= ST_REQ;
              end
              DEC_PASS: begin
                done    <= 1'b1;
                pass    <= 1'b1;
                state_q <= ST_IDLE;
              end
              default: begin
                done    <= 1'b1;
                fail    <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_addr      = addr_q;
  assign busy         = (state_q != ST_IDLE);

endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rd_rsp_valid,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          timeout,
  input logic [CW-1:0] read_count
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

  assert_no_req_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid);

  assert_no_req_after_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);

  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({pass, fail}) == 1);

  assert_verdict_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail || timeout) |-> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_rsp_valid));

  assert_timeout_is_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rsp_valid && !start |=> $stable(read_count));

endmodule

bind flash_status_poller flash_status_poller_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .busy         (busy),
  .done         (done),
  .pass         (pass),
  .fail         (fail),
  .timeout      (timeout),
  .read_count   (read_count)
);

// File: tb/tb_flash_status_poller.sv
module tb_flash_status_poller;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_program = 1'b0;
  logic          mode_toggle = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    exp_data = '0;
  logic [CW-1:0] poll_limit = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [7:0]    rd_rsp_data = '0;
  logic          busy, done, pass, fail, timeout;
  logic [CW-1:0] read_count;

  typedef struct {
    bit    pas;
    bit    tmo;
    int    cnt;
    string tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] rsp_q[$];
  logic [AW-1:0] cur_addr = '0;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit pend = 0;
  bit finished = 0;

  flash_status_poller #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_program(op_program),
    .mode_toggle(mode_toggle), .addr(addr), .exp_data(exp_data),
    .poll_limit(poll_limit), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .busy(busy),
    .done(done), .pass(pass), .fail(fail), .timeout(timeout),
    .read_count(read_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // device model and scoreboard monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(0, "WDOG", "watchdog expired", cyc, WATCHDOG);
        finish_run();
      end
      rd_rsp_valid = 1'b0;
      if (pend) begin
        pend = 0;
        rd_rsp_valid = 1'b1;
        if (rsp_q.size() != 0) rd_rsp_data = rsp_q.pop_front();
        else begin
          rd_rsp_data = 8'h00;
          chk(0, "R12", "read beyond the expected sequence", 1, 0);
        end
      end
      if (done) begin
        if (sb_q.size() == 0) chk(0, "R10", "done with nothing expected", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(pass == e.pas, e.tag, "pass", pass, e.pas);
          chk(fail == !e.pas, e.tag, "fail", fail, !e.pas);
          chk(timeout == e.tmo, "R9", {e.tag, " timeout"}, timeout, e.tmo);
          chk(read_count == CW'(e.cnt), "R11", {e.tag, " read_count"}, read_count, e.cnt);
        end
      end
      rd_req_ready = (cyc % 3) != 1;  // periodic back-pressure
      if (rd_req_valid && rd_req_ready) begin
        pend = 1;
        chk(rd_addr == cur_addr, "R2", "request address", rd_addr, cur_addr);
      end
    end
  end

  task automatic run_op(input string tag, input bit tgl, input bit prog,
                        input logic [AW-1:0] a, input logic [7:0] ex,
                        input int lim, input bit ep, input bit et,
                        input int ec, input bit poke);
    exp_t e;
    e.pas = ep; e.tmo = et; e.cnt = ec; e.tag = tag;
    sb_q.push_back(e);
    cur_addr = a;
    @(negedge clk);
    start = 1'b1; mode_toggle = tgl; op_program = prog; addr = a;
    exp_data = ex; poll_limit = CW'(lim);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      start = 1'b1; addr = a ^ 16'hFFFF; mode_toggle = ~tgl; exp_data = ~ex;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    chk(rsp_q.size() == 0, tag, "scripted reads left unused", rsp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R10", {tag, " quiet after done"}, {done, busy}, 0);
    chk(read_count == CW'(ec), "R11", {tag, " count held"}, read_count, ec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req_valid && !done && !pass && !fail && !timeout,
        "R1", "outputs in reset", {busy, rd_req_valid, done, pass, fail, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid && read_count == 0, "R1", "idle after reset",
        {busy, rd_req_valid, read_count}, 0);

    // R3/R4 data polling, erase: expected bit 7 is 1
    rsp_q = '{8'h00, 8'h00, 8'h80};
    run_op("R3_erase", 0, 0, 16'h1200, 8'h00, 16, 1, 0, 3, 0);
    // R2 start while busy ignored
    rsp_q = '{8'h00, 8'h10, 8'h00, 8'h80};
    run_op("R2_busy_start", 0, 0, 16'h0456, 8'h00, 16, 1, 0, 4, 1);
    // R4/R8 program, bit 7 follows data, then verify passes
    rsp_q = '{8'h80, 8'h80, 8'h5A, 8'h5A};
    run_op("R8_prog_ok", 0, 1, 16'h2001, 8'h5A, 16, 1, 0, 4, 0);
    // R8 verify mismatch
    rsp_q = '{8'h5B, 8'h5B};
    run_op("R8_verify_bad", 0, 1, 16'h2002, 8'h5A, 16, 0, 0, 2, 0);
    // R5 error then match
    rsp_q = '{8'h20, 8'h80};
    run_op("R5_recheck_ok", 0, 0, 16'h3000, 8'h00, 16, 1, 0, 2, 0);
    // R5 error then no match
    rsp_q = '{8'h20, 8'h20};
    run_op("R5_recheck_bad", 0, 0, 16'h3001, 8'h00, 16, 0, 0, 2, 0);
    // R6 toggle, erase
    rsp_q = '{8'h40, 8'h00, 8'h40, 8'h40};
    run_op("R6_toggle", 1, 0, 16'h4000, 8'h00, 16, 1, 0, 4, 0);
    // R6 equal pair with error bit set still settles
    rsp_q = '{8'h60, 8'h60};
    run_op("R6_err_ignored", 1, 0, 16'h4001, 8'h00, 16, 1, 0, 2, 0);
    // R7 error, new pair steady
    rsp_q = '{8'h40, 8'h20, 8'h60, 8'h60};
    run_op("R7_pair_ok", 1, 0, 16'h5000, 8'h00, 16, 1, 0, 4, 0);
    // R7 error, new pair still toggling
    rsp_q = '{8'h40, 8'h20, 8'h60, 8'h20};
    run_op("R7_pair_bad", 1, 0, 16'h5001, 8'h00, 16, 0, 0, 4, 0);
    // R8 toggle program with verify
    rsp_q = '{8'h40, 8'h40, 8'h33};
    run_op("R8_toggle_prog", 1, 1, 16'h6000, 8'h33, 16, 1, 0, 3, 0);
    // R9 limit exhausted
    rsp_q = '{8'h00, 8'h00, 8'h00};
    run_op("R9_timeout", 0, 0, 16'h7000, 8'h00, 3, 0, 1, 3, 0);
    // R9 settle on last allowed read
    rsp_q = '{8'h00, 8'h00, 8'h80};
    run_op("R9_last_read", 0, 0, 16'h7001, 8'h00, 3, 1, 0, 3, 0);
    // R9 verify read beyond limit
    rsp_q = '{8'h11, 8'h11};
    run_op("R9_verify_free", 0, 1, 16'h7002, 8'h11, 1, 1, 0, 2, 0);
    // R9 toggle timeout
    rsp_q = '{8'h40, 8'h00};
    run_op("R9_toggle_tmo", 1, 0, 16'h7003, 8'h00, 2, 0, 1, 2, 0);

    finish_run();
  end

endmodule